// File: doc/BRIEF.md
# Serial Register Target with Frame-Length Check

This block is the device side of a four-wire serial link with a clock, an active-low select, a data-in line and a data-out line. A host reaches a small register file through it. The host sends fixed 32-bit command words while holding select low. Each word is either a read or a write of one register. The target answers every word with a 32-bit reply. That reply holds the contents of the register that the *previous* valid word addressed, so read data always lags one frame behind the command that asked for it.

The serial clock idles low. The target samples its data input on each rising serial clock edge. It moves its data output after each falling edge, so the value is settled when the host samples it at the next rising edge. The serial pins are passed through synchronisers into a faster system clock, and all edges are detected in that clock domain.

The target counts the rising serial edges seen while select is low. A frame is accepted only if that count is exactly 32. Any other count discards the frame and raises a sticky clock-count fault. The fault is shown on a pin and in the top bit of every later reply. It is cleared only by a valid write to a dedicated status address.

Top module: `spi_cmd_target`

## Requirements
- R1: A frame is shifted most significant bit first, with the data-in line sampled on each rising serial clock while select is low. Bit 31 selects write (1) or read (0), bits 30:24 carry the address and bits 23:0 carry the write data. A read frame never changes a register, whatever its data field holds.
- R2: The data-out line changes only after a falling serial clock edge. The first reply bit is driven once select has been low for 4 system clocks, in time for the first rising edge.
- R3: The reply of a frame is {fault flag in bit 31, previous valid address in bits 30:24, read data of that address in bits 23:0}. Both the previous address and the read data are taken at the moment select falls.
- R4: A valid write to an address below NUM_REGS (8) stores the 24-bit data. The stored value is returned in the reply to the frame that follows any valid frame addressing it.
- R5: When select rises after a count of rising edges other than 32, such as 31 or 33, the fault flag is set and the clk_fault output goes high.
- R6: A frame with a wrong edge count is discarded. No register is written, and the previous-address pointer keeps its old value.
- R7: The fault flag is sticky. Only a valid write frame to address 0x7F clears it, and the next reply then shows bit 31 low.
- R8: Address 0x7F reads back the fault flag in data bit 0 and zero elsewhere. Every other address at or above NUM_REGS reads as zero, and writes to such addresses are dropped.
- R9: After reset the fault flag is low, the pointer is 0, all registers are 0, and the data-out line is low while select is high.
- R10: The edge counter saturates at 33, so a frame of 96 edges, which a 6-bit counter would otherwise wrap to 32, is still flagged as a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low frame select from the host |
| mosi | input | 1 | Serial data from host to target |
| miso | output | 1 | Serial data from target to host, low while not selected |
| clk_fault | output | 1 | Sticky clock-count fault flag |

## Verification
Every address of the register file is written with a different computed value and then read back. Because the data is distinct per address, a stuck or swapped pointer or an off-by-one frame lag shows up in the reply. Frames are also sent to addresses outside the file, to the status address, and as read words carrying nonzero data, which separates real writes from dropped ones. Frames of 31, 33 and 96 edges each follow a pending write. The 31 and 33 cases show that the count is checked on both sides of 32. The 96 case shows that the counter saturates rather than wraps. The reply after each bad frame shows that neither the write nor the pointer update leaked through.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } cmd_kind_e;

    function automatic logic [7:0] sat_inc8(input logic [7:0] v, input logic [7:0] lim);
        return (v >= lim) ? lim : v + 8'd1;
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic frame_start_o,
    output logic frame_end_o,
    output logic cs_active_o,
    output logic mosi_o
);

    typedef struct packed {
        logic [STAGES-1:0] sclk_p;
        logic [STAGES-1:0] cs_p;
        logic [STAGES-1:0] mosi_p;
        logic              sclk_last;
        logic              cs_last;
    } sync_state_t;

    localparam sync_state_t SYNC_RESET = '{
        sclk_p:    '0,
        cs_p:      '1,
        mosi_p:    '0,
        sclk_last: 1'b0,
        cs_last:   1'b1
    };

    sync_state_t sync_d, sync_q;
    logic sclk_s, cs_s;

    assign sclk_s = sync_q.sclk_p[STAGES-1];
    assign cs_s   = sync_q.cs_p[STAGES-1];

    always_comb begin
        sync_d           = sync_q;
        sync_d.sclk_p    = (sync_q.sclk_p << 1) | STAGES'(sclk_i);
        sync_d.cs_p      = (sync_q.cs_p   << 1) | STAGES'(cs_n_i);
        sync_d.mosi_p    = (sync_q.mosi_p << 1) | STAGES'(mosi_i);
        sync_d.sclk_last = sclk_s;
        sync_d.cs_last   = cs_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= SYNC_RESET;
        else        sync_q <= sync_d;
    end

    assign sclk_rise_o   = sclk_s & ~sync_q.sclk_last;
    assign sclk_fall_o   = ~sclk_s & sync_q.sclk_last;
    assign frame_start_o = ~cs_s & sync_q.cs_last;
    assign frame_end_o   = cs_s & ~sync_q.cs_last;
    assign cs_active_o   = ~cs_s;
    assign mosi_o        = sync_q.mosi_p[STAGES-1];

endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
    parameter int FRAME_BITS = 32,
    parameter int CNT_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise_i,
    input  logic                  sclk_fall_i,
    input  logic                  mosi_i,
    input  logic                  cs_active_i,
    input  logic                  frame_start_i,
    input  logic [FRAME_BITS-1:0] reply_i,
    output logic                  miso_o,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  frame_ok_o
);

    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] rx;
        logic [FRAME_BITS-1:0] tx;
        logic [CNT_W-1:0]      cnt;
    } shift_state_t;

    shift_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (frame_start_i) begin
            sh_d.tx  = reply_i;
            sh_d.rx  = '0;
            sh_d.cnt = '0;
        end else if (cs_active_i) begin
            if (sclk_rise_i) begin
                sh_d.rx  = {sh_q.rx[FRAME_BITS-2:0], mosi_i};
                sh_d.cnt = (sh_q.cnt >= CNT_SAT) ? CNT_SAT : sh_q.cnt + 1'b1;
            end
            if (sclk_fall_i) begin
                sh_d.tx = {sh_q.tx[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign miso_o     = cs_active_i & sh_q.tx[FRAME_BITS-1];
    assign frame_o    = sh_q.rx;
    assign frame_ok_o = (sh_q.cnt == CNT_GOOD);

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.cnt <= CNT_SAT) else $error("edge counter beyond saturation"); // R10

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (sh_q.cnt == '0)) else $error("counter not cleared at frame start"); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active_i && sclk_rise_i && !frame_start_i && sh_q.cnt < CNT_SAT)
        |=> (sh_q.cnt == $past(sh_q.cnt) + 1'b1)) else $error("counter missed an edge"); // R5

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active_i && !sclk_fall_i && !frame_start_i) |=> $stable(sh_q.tx))
        else $error("output moved without falling edge"); // R2

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
    import spi_tgt_pkg::*;
#(
    parameter int                ADDR_W      = 7,
    parameter int                DATA_W      = 24,
    parameter int                NUM_REGS    = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h7F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_done_i,
    input  logic                     frame_ok_i,
    input  logic [ADDR_W+DATA_W:0]   frame_i,
    output logic [ADDR_W+DATA_W:0]   reply_o,
    output logic                     fault_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [ADDR_W-1:0]               prev;
        logic                            fault;
    } reg_state_t;

    reg_state_t rf_d, rf_q;

    cmd_kind_e          cmd_kind;
    logic [ADDR_W-1:0]  cmd_addr;
    logic [DATA_W-1:0]  cmd_data;
    logic               commit;
    logic               status_clear;
    logic [NUM_REGS-1:0] wr_hit;
    logic [DATA_W-1:0]  rd_data;

    assign cmd_kind = cmd_kind_e'(frame_i[ADDR_W+DATA_W]);
    assign cmd_addr = frame_i[ADDR_W+DATA_W-1:DATA_W];
    assign cmd_data = frame_i[DATA_W-1:0];
    assign commit   = frame_done_i & frame_ok_i;
    assign status_clear = commit && (cmd_kind == CMD_WRITE) && (cmd_addr == STATUS_ADDR);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_hit
        assign wr_hit[gi] = commit && (cmd_kind == CMD_WRITE) &&
                            (cmd_addr == ADDR_W'(gi));
    end

    always_comb begin
        if (rf_q.prev < REG_LIMIT)
            rd_data = rf_q.regs[rf_q.prev[IDX_W-1:0]];
        else if (rf_q.prev == STATUS_ADDR)
            rd_data = DATA_W'(rf_q.fault);
        else
            rd_data = '0;
    end

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_hit[i]) rf_d.regs[i] = cmd_data;
        end
        if (frame_done_i) begin
            if (frame_ok_i) begin
                rf_d.prev = cmd_addr;
                if (status_clear) rf_d.fault = 1'b0;
            end else begin
                rf_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign reply_o = {rf_q.fault, rf_q.prev, rd_data};
    assign fault_o = rf_q.fault;

    AST_BAD_SETS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !frame_ok_i) |=> rf_q.fault) else $error("bad frame not flagged"); // R5

    AST_BAD_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !frame_ok_i) |=> $stable(rf_q.prev)) else $error("pointer moved on bad frame"); // R6

    AST_BAD_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !frame_ok_i) |=> $stable(rf_q.regs)) else $error("register written on bad frame"); // R6

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_q.fault && !(frame_done_i && frame_ok_i && cmd_kind == CMD_WRITE && cmd_addr == STATUS_ADDR))
        |=> rf_q.fault) else $error("fault dropped without clear"); // R7

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && cmd_kind == CMD_READ) |=> $stable(rf_q.regs)) else $error("read frame wrote"); // R1

endmodule

// File: rtl/spi_cmd_target.sv
module spi_cmd_target #(
    parameter int                ADDR_W      = 7,
    parameter int                DATA_W      = 24,
    parameter int                NUM_REGS    = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h7F,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic clk_fault
);

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    logic                  sclk_rise, sclk_fall, frame_start, frame_end, cs_active, mosi_s;
    logic [FRAME_BITS-1:0] frame_word, reply_word;
    logic                  frame_ok;

    spi_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_i        (sclk),
        .cs_n_i        (cs_n),
        .mosi_i        (mosi),
        .sclk_rise_o   (sclk_rise),
        .sclk_fall_o   (sclk_fall),
        .frame_start_o (frame_start),
        .frame_end_o   (frame_end),
        .cs_active_o   (cs_active),
        .mosi_o        (mosi_s)
    );

    spi_tgt_shift #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_rise_i   (sclk_rise),
        .sclk_fall_i   (sclk_fall),
        .mosi_i        (mosi_s),
        .cs_active_i   (cs_active),
        .frame_start_i (frame_start),
        .reply_i       (reply_word),
        .miso_o        (miso),
        .frame_o       (frame_word),
        .frame_ok_o    (frame_ok)
    );

    spi_tgt_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .NUM_REGS    (NUM_REGS),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done_i (frame_end),
        .frame_ok_i   (frame_ok),
        .frame_i      (frame_word),
        .reply_o      (reply_word),
        .fault_o      (clk_fault)
    );

endmodule

// File: tb/spi_cmd_target_tb.sv
module spi_cmd_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, clk_fault;

    int checks = 0;
    int fails  = 0;

    logic [23:0] m_regs [8];
    logic [6:0]  m_prev;
    logic        m_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_target u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .clk_fault(clk_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reply();
        logic [23:0] rd;
        if (m_prev < 7'd8)        rd = m_regs[m_prev[2:0]];
        else if (m_prev == 7'h7F) rd = {23'b0, m_fault};
        else                      rd = 24'h0;
        return {m_fault, m_prev, rd};
    endfunction

    function automatic logic [23:0] pat(input int a);
        return 24'h5A3C00 ^ 24'(a * 24'h013579) ^ 24'(a);
    endfunction

    task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
        rx = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = (i < 32) ? tx[31-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            rx = {rx[30:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic frame(input string tag, input logic w, input logic [6:0] a, input logic [23:0] d);
        logic [31:0] rx, exp;
        exp = exp_reply();
        xfer({w, a, d}, 32, rx);
        chk(tag, rx, exp);
        if (w) begin
            if (a < 7'd8)        m_regs[a[2:0]] = d;
            else if (a == 7'h7F) m_fault = 1'b0;
        end
        m_prev = a;
    endtask

    task automatic bad_frame(input string tag, input logic [6:0] a, input logic [23:0] d, input int n);
        logic [31:0] rx;
        xfer({1'b1, a, d}, n, rx);
        m_fault = 1'b1;
        chk(tag, {31'b0, clk_fault}, 32'd1);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_prev  = '0;
        m_fault = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9 reset state at the ports
        chk("R9 fault after reset", {31'b0, clk_fault}, 32'd0);
        chk("R9 miso idle", {31'b0, miso}, 32'd0);

        // R3 R9 first reply shows reset pointer and zero data
        frame("R9 R3 first reply", 1'b0, 7'd0, 24'h0);

        // R1 R2 R4 write sweep over every register
        for (int a = 0; a < 8; a++) frame("R2 R4 write sweep", 1'b1, 7'(a), pat(a));
        // R3 R4 read sweep, pipelined reply
        for (int a = 0; a < 8; a++) frame("R3 R4 read sweep", 1'b0, 7'(a), 24'hFFFFFF);
        frame("R3 R4 last read", 1'b0, 7'd0, 24'h0);

        // R1 read frame with nonzero data does not write
        frame("R1 read with data", 1'b0, 7'd3, 24'h123456);
        frame("R1 reg3 unchanged", 1'b0, 7'd3, 24'h0);

        // R8 out-of-range addresses read zero, writes dropped
        for (int a = 8; a < 16; a++) frame("R8 high write", 1'b1, 7'(a), pat(a));
        for (int a = 8; a < 16; a++) frame("R8 high read", 1'b0, 7'(a), 24'h0);
        frame("R8 mid write", 1'b1, 7'h40, 24'hABCDEF);
        frame("R8 mid read", 1'b0, 7'h40, 24'h0);
        frame("R8 back to reg", 1'b0, 7'd2, 24'h0);

        // R5 R6 short frame of 31 edges
        bad_frame("R5 short 31", 7'd2, 24'hDEAD00, 31);
        frame("R6 pointer kept after short", 1'b0, 7'd2, 24'h0);
        frame("R6 reg2 unchanged", 1'b0, 7'h7F, 24'h0);
        // R8 status data bit, R7 fault still set
        frame("R8 R7 status shows fault", 1'b1, 7'h7F, 24'h0);
        chk("R7 clk_fault cleared", {31'b0, clk_fault}, 32'd0);
        frame("R7 reply fault cleared", 1'b0, 7'd5, 24'h0);

        // R5 long frame of 33 edges
        bad_frame("R5 long 33", 7'd5, 24'h00BEEF, 33);
        frame("R6 R7 after long", 1'b0, 7'd1, 24'h0);
        chk("R7 fault held", {31'b0, clk_fault}, 32'd1);
        frame("R7 clear again", 1'b1, 7'h7F, 24'h0);

        // R10 96 edges must not wrap to a valid count
        bad_frame("R10 wrap 96", 7'd1, 24'h777777, 96);
        frame("R10 R6 reg1 kept", 1'b0, 7'd1, 24'h0);
        frame("R10 reply shows", 1'b1, 7'h7F, 24'h0);
        frame("R7 final clear", 1'b0, 7'd0, 24'h0);
        chk("R9 miso idle end", {31'b0, miso}, 32'd0);

        finish_run();
    end

endmodule